// File: doc/BRIEF.md
# Flush-to-zero floating-point multiplier

This block multiplies two 32-bit binary floating-point numbers in a fixed four-stage pipeline on a single clock. Each operand arrives on its own valid/ready channel; the two channels are joined, so a pair is taken only in a cycle where both operands are offered and the pipeline can move. The product leaves on one valid/ready output channel together with three status flags: overflow, underflow and invalid operation.

The arithmetic uses a reduced exception model that saves logic. Subnormal inputs are read as signed zeros. Results too small for the normal range become signed zeros. Every NaN input is treated as quiet, and the output is then one canonical quiet NaN. Finite products are normalised and rounded to nearest with ties to even. When the output is held by back-pressure, every stage of the pipeline freezes, so no result is dropped or repeated.

Top module: `ftz_fmul`

## Requirements
- R1: Words use bit 31 as sign, bits 30:23 as a biased exponent (bias 127) and bits 22:0 as the stored fraction below a hidden leading one. For two normal operands whose product lies in the normal range, out_data is the exact product rounded to nearest (error at most half a unit in the last place), and all three flags are low.
- R2: When the exact product lies exactly halfway between two representable values, the result is the one whose fraction LSB (bit 0) is zero.
- R3: An operand with exponent field 0 and a non-zero fraction is read as a zero that keeps its own sign. Its product with any finite operand is a zero whose sign is the XOR of the two operand signs, and all flags are low.
- R4: If the biased exponent after rounding would be below 1, the result is zero with the XOR sign (bits 30:0 all zero) and out_underflow is high.
- R5: If the biased exponent after rounding would be 255 or more, the result is infinity (exponent 0xFF, fraction 0) with the XOR sign and out_overflow is high. At most one flag is ever high.
- R6: If either operand is a NaN (exponent 0xFF, non-zero fraction), quiet or signaling, the result is 0x7FC00000 and all flags are low. This takes precedence over every other case.
- R7: A zero (including a flushed subnormal) times an infinity gives 0x7FC00000 with out_invalid high.
- R8: An infinity times a non-zero, non-NaN operand gives infinity with the XOR sign and no flag. A true zero times a finite operand gives zero with the XOR sign and no flag.
- R9: A pair accepted in cycle c appears on the output in cycle c+4 when the output is not stalled.
- R10: While out_valid is high and out_ready is low, out_data and the flags hold steady and the whole pipeline freezes. Every accepted pair yields exactly one result, in order.
- R11: a_ready equals b_valid AND NOT stall, and b_ready equals a_valid AND NOT stall, where stall is out_valid AND NOT out_ready. A pair is accepted only when both valids and both readies are high.
- R12: After synchronous reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | First operand offered |
| a_ready | output | 1 | First operand taken this cycle if a_valid |
| a_data | input | 32 | First operand word |
| b_valid | input | 1 | Second operand offered |
| b_ready | output | 1 | Second operand taken this cycle if b_valid |
| b_data | input | 32 | Second operand word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink accepts the result |
| out_data | output | 32 | Product word |
| out_overflow | output | 1 | Result saturated to infinity |
| out_underflow | output | 1 | Result flushed to zero |
| out_invalid | output | 1 | Zero times infinity |

## Verification
The first pattern set is a full cross of twenty chosen words: signed zeros, signed subnormals, ±1, 1.5, 2, 0.5, the smallest and largest normals, infinities, a quiet NaN, a signaling NaN, and values one ulp from one. This cross separates the precedence of NaN, zero-times-infinity, infinity and zero handling, and shows whether a subnormal keeps its sign. Directed pairs then land exactly on halfway points with odd and with even kept fractions, which tells tie-to-even apart from plain round-half-up. Random pairs with exponents pushed to both ends of the range exercise overflow, underflow and the rounding carry into the exponent. The random pairs arrive under random valid gaps on each input and random output back-pressure, which exposes lost, duplicated or reordered results.

// File: rtl/ftz_fmul_pkg.sv
package ftz_fmul_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int SEXP_W = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [1:0] {CLS_ZERO, CLS_NORM, CLS_INF, CLS_NAN} fclass_e;
    typedef enum logic [1:0] {SPC_NONE, SPC_ZERO, SPC_INF, SPC_QNAN} special_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
        fclass_e           cls;
    } operand_t;

    // stage 1: classified operands
    typedef struct packed {
        logic              sign;
        special_e          spc;
        logic              inv;
        logic [EXP_W-1:0]  exp_a;
        logic [EXP_W-1:0]  exp_b;
        logic [SIG_W-1:0]  sig_a;
        logic [SIG_W-1:0]  sig_b;
    } unpk_t;

    // stage 2: raw product and unadjusted exponent
    typedef struct packed {
        logic              sign;
        special_e          spc;
        logic              inv;
        logic [SEXP_W-1:0] sexp;
        logic [PROD_W-1:0] prod;
    } prod_t;

    // stage 3: normalised significand with round bits
    typedef struct packed {
        logic              sign;
        special_e          spc;
        logic              inv;
        logic [SEXP_W-1:0] sexp;
        logic [SIG_W-1:0]  sig;
        logic              g;
        logic              st;
    } norm_t;

    // stage 4: packed result
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              ovf;
        logic              unf;
        logic              inv;
    } result_t;

    function automatic operand_t unpack_op(input logic [WORD_W-1:0] w);
        operand_t         o;
        logic [EXP_W-1:0] e;
        logic [FRAC_W-1:0] f;
        e      = w[WORD_W-2 -: EXP_W];
        f      = w[FRAC_W-1:0];
        o.sign = w[WORD_W-1];
        o.exp  = e;
        o.sig  = {1'b1, f};
        if (e == '0)
            o.cls = CLS_ZERO;
        else if (e == {EXP_W{1'b1}})
            o.cls = (f == '0) ? CLS_INF : CLS_NAN;
        else
            o.cls = CLS_NORM;
        return o;
    endfunction

    function automatic logic [WORD_W-1:0] inf_word(input logic s);
        return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] zero_word(input logic s);
        return {s, {(WORD_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/ftz_fmul_unpack.sv
module ftz_fmul_unpack
    import ftz_fmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    output logic              out_valid,
    output unpk_t             out_q
);

    operand_t ua, ub;
    unpk_t    d;
    logic     any_nan, any_inf, any_zero;

    always_comb begin
        ua       = unpack_op(a_word);
        ub       = unpack_op(b_word);
        any_nan  = (ua.cls == CLS_NAN)  || (ub.cls == CLS_NAN);
        any_inf  = (ua.cls == CLS_INF)  || (ub.cls == CLS_INF);
        any_zero = (ua.cls == CLS_ZERO) || (ub.cls == CLS_ZERO);

        d.sign  = ua.sign ^ ub.sign;
        d.exp_a = ua.exp;
        d.exp_b = ub.exp;
        d.sig_a = ua.sig;
        d.sig_b = ub.sig;
        d.inv   = 1'b0;
        // precedence: NaN, zero*inf, inf, zero, finite
        if (any_nan) begin
            d.spc = SPC_QNAN;
        end else if (any_inf && any_zero) begin
            d.spc = SPC_QNAN;
            d.inv = 1'b1;
        end else if (any_inf) begin
            d.spc = SPC_INF;
        end else if (any_zero) begin
            d.spc = SPC_ZERO;
        end else begin
            d.spc = SPC_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      out_valid <= 1'b0;
        else if (adv) out_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (adv) out_q <= d;
    end

    // R6: a NaN-class result never carries the invalid flag unless it came from zero*inf
    assert_nan_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (adv && in_valid && ((ua.cls == CLS_NAN) || (ub.cls == CLS_NAN)))
        |=> (out_q.spc == SPC_QNAN) && !out_q.inv);

endmodule

// File: rtl/ftz_fmul_mult.sv
module ftz_fmul_mult
    import ftz_fmul_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  logic  in_valid,
    input  unpk_t in_q,
    output logic  out_valid,
    output prod_t out_q
);

    prod_t d;

    always_comb begin
        d.sign = in_q.sign;
        d.spc  = in_q.spc;
        d.inv  = in_q.inv;
        d.sexp = SEXP_W'(in_q.exp_a) + SEXP_W'(in_q.exp_b) - SEXP_W'(BIAS);
        d.prod = PROD_W'(in_q.sig_a) * PROD_W'(in_q.sig_b);
    end

    always_ff @(posedge clk) begin
        if (rst)      out_valid <= 1'b0;
        else if (adv) out_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (adv) out_q <= d;
    end

endmodule

// File: rtl/ftz_fmul_norm.sv
module ftz_fmul_norm
    import ftz_fmul_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  logic  in_valid,
    input  prod_t in_q,
    output logic  out_valid,
    output norm_t out_q
);

    norm_t d;

    always_comb begin
        d.sign = in_q.sign;
        d.spc  = in_q.spc;
        d.inv  = in_q.inv;
        if (in_q.prod[PROD_W-1]) begin
            // product in [2,4): shift right by one, bump exponent
            d.sig  = in_q.prod[PROD_W-1 -: SIG_W];
            d.g    = in_q.prod[PROD_W-1-SIG_W];
            d.st   = |in_q.prod[PROD_W-2-SIG_W:0];
            d.sexp = in_q.sexp + SEXP_W'(1);
        end else begin
            d.sig  = in_q.prod[PROD_W-2 -: SIG_W];
            d.g    = in_q.prod[PROD_W-2-SIG_W];
            d.st   = |in_q.prod[PROD_W-3-SIG_W:0];
            d.sexp = in_q.sexp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      out_valid <= 1'b0;
        else if (adv) out_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (adv) out_q <= d;
    end

    // R1: a finite product always leaves this stage with its leading one in place
    assert_norm_lead_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_q.spc == SPC_NONE) |-> out_q.sig[SIG_W-1]);

endmodule

// File: rtl/ftz_fmul_round.sv
module ftz_fmul_round
    import ftz_fmul_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    input  logic    in_valid,
    input  norm_t   in_q,
    output logic    out_valid,
    output result_t out_q
);

    localparam logic [SEXP_W-1:0] EMAX_S = SEXP_W'(EXP_MAX);
    localparam logic [SEXP_W-1:0] EMIN_S = SEXP_W'(1);

    result_t           d;
    logic              inc;
    logic [SIG_W:0]    rounded;
    logic [SEXP_W-1:0] e_rnd;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        inc     = in_q.g & (in_q.st | in_q.sig[0]);
        rounded = {1'b0, in_q.sig} + {{SIG_W{1'b0}}, inc};
        e_rnd   = in_q.sexp + SEXP_W'(rounded[SIG_W]);
        frac    = rounded[SIG_W] ? rounded[SIG_W-1:1] : rounded[FRAC_W-1:0];

        d      = '0;
        d.inv  = in_q.inv;
        unique case (in_q.spc)
            SPC_QNAN: d.word = QNAN_WORD;
            SPC_INF:  d.word = inf_word(in_q.sign);
            SPC_ZERO: d.word = zero_word(in_q.sign);
            default: begin
                if ($signed(e_rnd) >= $signed(EMAX_S)) begin
                    d.word = inf_word(in_q.sign);
                    d.ovf  = 1'b1;
                end else if ($signed(e_rnd) < $signed(EMIN_S)) begin
                    d.word = zero_word(in_q.sign);
                    d.unf  = 1'b1;
                end else begin
                    d.word = {in_q.sign, e_rnd[EXP_W-1:0], frac};
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)      out_valid <= 1'b0;
        else if (adv) out_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (adv) out_q <= d;
    end

    // R5: the three status flags are mutually exclusive
    assert_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0({out_q.ovf, out_q.unf, out_q.inv}));

endmodule

// File: rtl/ftz_fmul.sv
module ftz_fmul
    import ftz_fmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [WORD_W-1:0] a_data,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic [WORD_W-1:0] b_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_overflow,
    output logic              out_underflow,
    output logic              out_invalid
);

    logic    adv;
    logic    v1, v2, v3, v4;
    unpk_t   q1;
    prod_t   q2;
    norm_t   q3;
    result_t q4;

    // a single advance enable freezes every stage while the output is held
    assign adv     = !out_valid || out_ready;
    assign a_ready = adv && b_valid;
    assign b_ready = adv && a_valid;

    ftz_fmul_unpack u_unpack (
        .clk(clk), .rst(rst), .adv(adv), .in_valid(a_valid && b_valid),
        .a_word(a_data), .b_word(b_data), .out_valid(v1), .out_q(q1)
    );

    ftz_fmul_mult u_mult (
        .clk(clk), .rst(rst), .adv(adv), .in_valid(v1), .in_q(q1),
        .out_valid(v2), .out_q(q2)
    );

    ftz_fmul_norm u_norm (
        .clk(clk), .rst(rst), .adv(adv), .in_valid(v2), .in_q(q2),
        .out_valid(v3), .out_q(q3)
    );

    ftz_fmul_round u_round (
        .clk(clk), .rst(rst), .adv(adv), .in_valid(v3), .in_q(q3),
        .out_valid(v4), .out_q(q4)
    );

    assign out_valid     = v4;
    assign out_data      = q4.word;
    assign out_overflow  = q4.ovf;
    assign out_underflow = q4.unf;
    assign out_invalid   = q4.inv;

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data)
            && $stable({out_overflow, out_underflow, out_invalid}));

    assert_invalid_qnan_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_invalid) |-> out_data == QNAN_WORD);

    assert_ovf_inf_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_overflow) |-> out_data[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

    assert_unf_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_underflow) |-> out_data[WORD_W-2:0] == '0);

endmodule

// File: tb/ftz_fmul_test.sv
module ftz_fmul_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        a_valid, b_valid, out_ready;
    logic        a_ready, b_ready, out_valid;
    logic [31:0] a_data, b_data, out_data;
    logic        out_overflow, out_underflow, out_invalid;

    always #2 clk = ~clk;

    ftz_fmul uut (
        .clk(clk), .rst(rst),
        .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
        .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_overflow(out_overflow), .out_underflow(out_underflow),
        .out_invalid(out_invalid)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] src_a[$];
    logic [31:0] src_b[$];
    logic [34:0] expq[$];
    string       tagq[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // expected {word, ovf, unf, inv}, computed through double-precision arithmetic
    function automatic logic [34:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            output string tag);
        int          ea, eb, e;
        logic [22:0] fa, fb;
        bit          s, za, zb, ia, ib, na, nb, suba, subb, g, st;
        real         da, db;
        logic [63:0] pb;
        logic [24:0] keep;
        ea = int'(a[30:23]); eb = int'(b[30:23]);
        fa = a[22:0];        fb = b[22:0];
        s  = a[31] ^ b[31];
        za = (ea == 0);  zb = (eb == 0);
        suba = za && fa != 0; subb = zb && fb != 0;
        ia = (ea == 255) && fa == 0; ib = (eb == 255) && fb == 0;
        na = (ea == 255) && fa != 0; nb = (eb == 255) && fb != 0;
        if (na || nb) begin tag = "R6"; return {32'h7FC00000, 3'b000}; end
        if ((za && ib) || (ia && zb)) begin tag = "R7"; return {32'h7FC00000, 3'b001}; end
        if (ia || ib) begin tag = "R8"; return {s, 8'hFF, 23'd0, 3'b000}; end
        if (za || zb) begin
            tag = (suba || subb) ? "R3" : "R8";
            return {s, 31'd0, 3'b000};
        end
        da = $bitstoreal({1'b0, 11'(ea + 896), fa, 29'd0});
        db = $bitstoreal({1'b0, 11'(eb + 896), fb, 29'd0});
        pb = $realtobits(da * db);
        e    = int'(pb[62:52]) - 896;
        keep = {2'b01, pb[51:29]};
        g    = pb[28];
        st   = |pb[27:0];
        tag  = (g && !st) ? "R2" : "R1";
        if (g && (st || keep[0])) begin
            keep = keep + 25'd1;
            if (keep[24]) begin keep = 25'h0800000; e = e + 1; end
        end
        if (e >= 255) begin tag = "R5"; return {s, 8'hFF, 23'd0, 3'b100}; end
        if (e <= 0)   begin tag = "R4"; return {s, 31'd0, 3'b010}; end
        return {s, 8'(e), keep[22:0], 3'b000};
    endfunction

    function automatic logic [31:0] rand_op();
        logic [31:0] w;
        w = $urandom;
        case ($urandom % 4)
            0: ;
            1: w[30:23] = 8'(100 + $urandom % 56);
            2: w[30:23] = 8'(1 + $urandom % 24);
            default: w[30:23] = 8'(230 + $urandom % 25);
        endcase
        return w;
    endfunction

    // drives queued pairs with random valid gaps; mode 0: always ready, 1: 3/4, 2: 1/2
    task automatic run_stream(input int mode);
        bit          hs_prev = 0, stall_prev = 0;
        logic [34:0] held = '0;
        logic [34:0] ex, act;
        string       tg;
        int          guard = 0;
        while ((src_a.size() > 0 || expq.size() > 0 || a_valid || b_valid) && guard < 100000) begin
            guard++;
            @(negedge clk);
            act = {out_data, out_overflow, out_underflow, out_invalid};
            if (stall_prev)
                check(out_valid && act == held, "R10", "held output during stall",
                      {28'd0, out_valid, act}, {29'd1, held});
            if (hs_prev) begin a_valid = 1'b0; b_valid = 1'b0; end
            if (!a_valid && !b_valid && src_a.size() > 0) begin
                a_data = src_a[0];
                b_data = src_b[0];
            end
            if (src_a.size() > 0) begin
                if (!a_valid && ($urandom % 3 != 0)) a_valid = 1'b1;
                if (!b_valid && ($urandom % 3 != 0)) b_valid = 1'b1;
            end
            out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? ($urandom % 4 != 0) : ($urandom % 2 == 0);
            #1;
            check(a_ready == (b_valid && (!out_valid || out_ready)) &&
                  b_ready == (a_valid && (!out_valid || out_ready)),
                  "R11", "ready join", {62'd0, a_ready, b_ready},
                  {62'd0, b_valid && (!out_valid || out_ready), a_valid && (!out_valid || out_ready)});
            hs_prev = a_valid && a_ready && b_valid && b_ready;
            if (hs_prev) begin
                ex = ref_mul(src_a[0], src_b[0], tg);
                expq.push_back(ex);
                tagq.push_back(tg);
                void'(src_a.pop_front());
                void'(src_b.pop_front());
            end
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R10", "result with nothing outstanding", {29'd0, act}, 64'd0);
                end else begin
                    ex = expq.pop_front();
                    tg = tagq.pop_front();
                    check(act == ex, tg, "product {data,ovf,unf,inv}", {29'd0, act}, {29'd0, ex});
                end
            end
            stall_prev = out_valid && !out_ready;
            held = act;
        end
        check(expq.size() == 0 && src_a.size() == 0, "R10", "all results delivered",
              64'(expq.size()), 64'd0);
    endtask

    logic [31:0] vals[20] = '{
        32'h00000000, 32'h80000000, 32'h00000001, 32'h807FFFFF,
        32'h3F800000, 32'hBF800000, 32'h3FC00000, 32'h7F7FFFFF,
        32'h00800000, 32'h80800000, 32'h7F800000, 32'hFF800000,
        32'h7FC00000, 32'h7F800001, 32'h40000000, 32'h3F000000,
        32'h3F800001, 32'h1F800000, 32'h5F800000, 32'hBFFFFFFF
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int          lat;
        logic [34:0] ex;
        string       tg;
        rst = 1'b1; a_valid = 1'b0; b_valid = 1'b0; out_ready = 1'b0;
        a_data = '0; b_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R12", "out_valid after reset", 64'(out_valid), 64'd0);
        check(!a_ready && !b_ready, "R11", "no ready without partner valid",
              {62'd0, a_ready, b_ready}, 64'd0);

        // R9: single pair, 1.5 * 2.0 = 3.0, four cycles from accept to output
        @(negedge clk);
        a_data = 32'h3FC00000; b_data = 32'h40000000;
        a_valid = 1'b1; b_valid = 1'b1; out_ready = 1'b1;
        #1;
        check(a_ready && b_ready, "R11", "pair accepted when idle",
              {62'd0, a_ready, b_ready}, 64'd3);
        @(negedge clk);
        a_valid = 1'b0; b_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 4, "R9", "latency in cycles", 64'(lat), 64'd4);
        check(out_data == 32'h40400000, "R1", "1.5*2.0", 64'(out_data), 64'h40400000);
        @(negedge clk);

        // ties: odd kept fraction rounds up, even stays
        ex = ref_mul(32'h3F800001, 32'h3FC00000, tg);
        check(ex[34:3] == 32'h3FC00002 && tg == "R2", "R2", "bench tie model odd",
              64'(ex[34:3]), 64'h3FC00002);
        src_a.push_back(32'h3F800001); src_b.push_back(32'h3FC00000);
        src_a.push_back(32'h3F800003); src_b.push_back(32'h3FC00000);
        src_a.push_back(32'hBF800001); src_b.push_back(32'h3FC00000);
        src_a.push_back(32'h00800000); src_b.push_back(32'h3F7FFFFF);
        src_a.push_back(32'h00800000); src_b.push_back(32'h3F800000);
        src_a.push_back(32'h7F7FFFFF); src_b.push_back(32'h3F800001);
        src_a.push_back(32'h3FFFFFFF); src_b.push_back(32'h3FFFFFFF);
        run_stream(0);

        for (int i = 0; i < 20; i++)
            for (int j = 0; j < 20; j++) begin
                src_a.push_back(vals[i]);
                src_b.push_back(vals[j]);
            end
        run_stream(1);

        for (int k = 0; k < 3000; k++) begin
            src_a.push_back(rand_op());
            src_b.push_back(rand_op());
        end
        run_stream(2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule